// File: doc/BRIEF.md
# Key-Protected Oscillator Control Register

This block is one 8-bit control register on a simple processor register bus. The bus has an address, a write strobe, write data, a read strobe and read data. The register holds the enables for three clock sources, the enables for two clock-failure detectors, and a 3-bit code that selects the system clock source. Its fields drive the oscillators, the failure-detection logic and the clock multiplexer directly.

The register is guarded against stray writes. A data write takes effect only after an unlock key of two bytes has been written to the register's own address. The key is the byte E7h followed by the byte 18h. Exactly one data write is then accepted, and the register locks itself again.

Nothing stops software from writing a value that turns off every clock and both detectors. The register holds that value until the reset input is asserted.

Top module: `osc_ctrl_reg`

## Requirements
- R1: After reset the stored value is A0h. The outputs `int_osc_en` and `wdt_osc_en` are 1, every other enable is 0, `clk_sel` is 0, and the lock state is LOCKED.
- R2: A write hits the register only when `bus_addr` equals F86h. The register unlocks only after a write of E7h followed by the very next hitting write of 18h. A data write made while LOCKED leaves the stored value unchanged.
- R3: In the state after E7h (KEY1), any hitting write other than 18h sends the lock back to LOCKED. A following 18h and data write are then ignored.
- R4: In the UNLOCKED state, one hitting write stores its data. In the next cycle `wr_accept` is 1 for exactly one cycle, and the lock returns to LOCKED, so a second data write is ignored.
- R5: The key writes E7h and 18h never change the stored value while the lock is LOCKED or KEY1.
- R6: Writes to any other address change neither the stored value nor the lock state.
- R7: When `bus_rd` is 1 and the address hits, `bus_rdata` returns the stored value; otherwise it is 0. Reads never change the lock state.
- R8: The field positions in the stored byte are as follows. Bit 7 is `int_osc_en`, bit 6 is `xtal_en`, bit 5 is `wdt_osc_en`, bit 4 is `sysclk_fd_en`, bit 3 is `wdt_fd_en`, and bits 2:0 are `clk_sel`. `xtal_pin_ovr` equals bit 6.
- R9: The all-zero value is accepted like any other value and is kept until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| int_osc_en | output | 1 | Internal precision oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| wdt_osc_en | output | 1 | Watchdog oscillator enable |
| sysclk_fd_en | output | 1 | System clock failure detection and recovery enable |
| wdt_fd_en | output | 1 | Watchdog oscillator failure detection enable |
| clk_sel | output | 3 | System clock source select |
| xtal_pin_ovr | output | 1 | Crystal pins take over from general-purpose I/O control |
| wr_accept | output | 1 | One-cycle pulse after each accepted data write |

## Verification
A write is presented at one falling edge and captured at the next rising edge. The field outputs and `wr_accept` are checked one half-cycle after that rising edge, because both come from registers updated at that edge. Read data is combinational from the stored value, so it is checked in the same low phase while `bus_rd` is held. A second check one cycle later confirms that `wr_accept` has dropped again. Key-state effects are not visible directly at the ports. They are checked through the outcome of a later data write, which the bench predicts with its own model of the three lock states.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_KEY1   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   // Field order is part of the behaviour: bit 7 first, select in bits 2:0
   typedef struct packed {
      logic       int_en;
      logic       xtal_en;
      logic       wdt_en;
      logic       sys_fd_en;
      logic       wdt_fd_en;
      logic [2:0] sel;
   } osc_fields_t;

   localparam int unsigned FIELD_W = $bits(osc_fields_t);

endpackage

// File: rtl/osc_key_fsm.sv
module osc_key_fsm
   import osc_ctrl_pkg::*;
#(
   parameter int unsigned          DATA_W = 8,
   parameter logic [DATA_W-1:0]    KEY_A  = 8'hE7,
   parameter logic [DATA_W-1:0]    KEY_B  = 8'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              commit,
   output key_state_e        state
);

   key_state_e state_d;

   generate
      if (KEY_A == KEY_B) begin : g_bad_keys
         $error("osc_key_fsm: both key bytes must differ");
      end
   endgenerate

   always_comb begin
      state_d = state;
      commit  = 1'b0;
      if (wr_hit) begin
         unique case (state)
            KS_LOCKED: state_d = (wdata == KEY_A) ? KS_KEY1 : KS_LOCKED;
            KS_KEY1:   state_d = (wdata == KEY_B) ? KS_OPEN : KS_LOCKED;
            KS_OPEN: begin
               commit  = 1'b1;
               state_d = KS_LOCKED;
            end
            default:   state_d = KS_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= KS_LOCKED;
      else        state <= state_d;
   end

   AST_RELOCK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> state == KS_LOCKED); // R4
   AST_SECOND_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && state == KS_KEY1 && wdata == KEY_B) |=> state == KS_OPEN); // R2
   AST_WRONG_SECOND_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && state == KS_KEY1 && wdata != KEY_B) |=> state == KS_LOCKED); // R3
   AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(state)); // R6

endmodule

// File: rtl/osc_field_store.sv
module osc_field_store
   import osc_ctrl_pkg::*;
#(
   parameter logic [FIELD_W-1:0] RESET_VAL = 8'hA0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  logic [FIELD_W-1:0] wdata,
   output osc_fields_t        q,
   output logic               accept_pulse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q            <= osc_fields_t'(RESET_VAL);
         accept_pulse <= 1'b0;
      end else begin
         accept_pulse <= commit;
         if (commit) q <= osc_fields_t'(wdata);
      end
   end

   AST_NO_CHANGE_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(q)); // R5
   AST_COMMIT_STORES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> q == $past(wdata)); // R4
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      accept_pulse |=> !accept_pulse); // R4

endmodule

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
   import osc_ctrl_pkg::*;
#(
   parameter int unsigned          ADDR_W    = 12,
   parameter int unsigned          DATA_W    = 8,
   parameter logic [ADDR_W-1:0]    REG_ADDR  = 12'hF86,
   parameter logic [DATA_W-1:0]    KEY_A     = 8'hE7,
   parameter logic [DATA_W-1:0]    KEY_B     = 8'h18,
   parameter logic [DATA_W-1:0]    RESET_VAL = 8'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              int_osc_en,
   output logic              xtal_en,
   output logic              wdt_osc_en,
   output logic              sysclk_fd_en,
   output logic              wdt_fd_en,
   output logic [2:0]        clk_sel,
   output logic              xtal_pin_ovr,
   output logic              wr_accept
);

   generate
      if (DATA_W != FIELD_W) begin : g_bad_width
         $error("osc_ctrl_reg: DATA_W must equal the field layout width");
      end
   endgenerate

   logic        hit;
   logic        wr_hit;
   logic        commit;
   key_state_e  key_state;
   osc_fields_t fields;

   assign hit    = (bus_addr == REG_ADDR);
   assign wr_hit = bus_wr && hit;

   osc_key_fsm #(
      .DATA_W (DATA_W),
      .KEY_A  (KEY_A),
      .KEY_B  (KEY_B)
   ) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .wdata  (bus_wdata),
      .commit (commit),
      .state  (key_state)
   );

   osc_field_store #(
      .RESET_VAL (RESET_VAL)
   ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .commit       (commit),
      .wdata        (bus_wdata),
      .q            (fields),
      .accept_pulse (wr_accept)
   );

   assign bus_rdata    = (bus_rd && hit) ? DATA_W'(fields) : '0;
   assign int_osc_en   = fields.int_en;
   assign xtal_en      = fields.xtal_en;
   assign wdt_osc_en   = fields.wdt_en;
   assign sysclk_fd_en = fields.sys_fd_en;
   assign wdt_fd_en    = fields.wdt_fd_en;
   assign clk_sel      = fields.sel;
   assign xtal_pin_ovr = fields.xtal_en;

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      key_state != 2'd3); // R2
   AST_ACCEPT_ONLY_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> !wr_accept); // R6

endmodule

// File: tb/osc_ctrl_reg_tb_top.sv
module osc_ctrl_reg_tb_top;

   localparam logic [11:0] A_REG = 12'hF86;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_rdata;
   logic        int_osc_en, xtal_en, wdt_osc_en, sysclk_fd_en, wdt_fd_en;
   logic [2:0]  clk_sel;
   logic        xtal_pin_ovr, wr_accept;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench model: 0 locked, 1 first key seen, 2 open
   int         m_state = 0;
   logic [7:0] m_val   = 8'hA0;

   always #4 clk = ~clk;

   osc_ctrl_reg dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .int_osc_en(int_osc_en), .xtal_en(xtal_en), .wdt_osc_en(wdt_osc_en),
      .sysclk_fd_en(sysclk_fd_en), .wdt_fd_en(wdt_fd_en), .clk_sel(clk_sel),
      .xtal_pin_ovr(xtal_pin_ovr), .wr_accept(wr_accept)
   );

   function automatic bit model_step(input logic [11:0] a, input logic [7:0] d);
      bit acc = 1'b0;
      if (a == A_REG) begin
         case (m_state)
            0: m_state = (d == 8'hE7) ? 1 : 0;
            1: m_state = (d == 8'h18) ? 2 : 0;
            default: begin m_state = 0; m_val = d; acc = 1'b1; end
         endcase
      end
      return acc;
   endfunction

   function automatic logic [7:0] pack_outs();
      return {int_osc_en, xtal_en, wdt_osc_en, sysclk_fd_en, wdt_fd_en, clk_sel};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // write at a falling edge, captured at the next rising edge, checked one half-cycle later
   task automatic wr(input logic [11:0] a, input logic [7:0] d, input string req);
      bit acc;
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      acc = model_step(a, d);
      check(req, {24'd0, pack_outs()}, {24'd0, m_val});
      check(req, {31'd0, wr_accept}, {31'd0, acc});
   endtask

   task automatic rd_check(input logic [11:0] a, input string req);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      check(req, {24'd0, bus_rdata}, {24'd0, (a == A_REG) ? m_val : 8'h00});
      bus_rd = 1'b0;
   endtask

   task automatic unlock();
      wr(A_REG, 8'hE7, "R5");
      wr(A_REG, 8'h18, "R5");
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C1A));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {24'd0, pack_outs()}, 32'hA0);
      check("R1", {31'd0, wr_accept}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_check(A_REG, "R7");
      // R2 locked data write ignored
      wr(A_REG, 8'h55, "R2");
      // R2 proper sequence, R4 accept
      unlock();
      wr(A_REG, 8'h4B, "R4");
      @(negedge clk);
      check("R4 pulse drops", {31'd0, wr_accept}, 32'd0);
      check("R8 xtal bit", {31'd0, xtal_pin_ovr}, {31'd0, m_val[6]});
      check("R8 sel", {29'd0, clk_sel}, {29'd0, m_val[2:0]});
      // R4 relock: second write ignored
      wr(A_REG, 8'hFF, "R4");
      // R3 abort from first key
      wr(A_REG, 8'hE7, "R3");
      wr(A_REG, 8'h19, "R3");
      wr(A_REG, 8'h18, "R3");
      wr(A_REG, 8'h33, "R3");
      // R6 other address between keys keeps state
      wr(A_REG, 8'hE7, "R6");
      wr(12'hF85, 8'h77, "R6");
      wr(A_REG, 8'h18, "R6");
      wr(A_REG, 8'h6C, "R6");
      // R7 read between keys keeps state, other address reads zero
      wr(A_REG, 8'hE7, "R7");
      @(negedge clk); rd_check(A_REG, "R7"); rd_check(12'h086, "R7");
      wr(A_REG, 8'h18, "R7");
      wr(A_REG, 8'hD2, "R7");
      // R8 key byte as data while open
      unlock();
      wr(A_REG, 8'hE7, "R8");
      check("R8 ovr", {31'd0, xtal_pin_ovr}, 32'd1);
      // R9 all zero stays
      unlock();
      wr(A_REG, 8'h00, "R9");
      repeat (5) @(negedge clk);
      check("R9", {24'd0, pack_outs()}, 32'h00);
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [11:0] a;
         logic [7:0]  d;
         int          r = $urandom_range(0, 9);
         a = ($urandom_range(0, 7) == 0) ? 12'($urandom) : A_REG;
         d = (r < 3) ? 8'hE7 : (r < 6) ? 8'h18 : 8'($urandom);
         wr(a, d, "R2/R4 random");
      end
      // reset again restores R1
      @(negedge clk); rst_n = 1'b0; #1;
      check("R1 rereset", {24'd0, pack_outs()}, 32'hA0);
      m_val = 8'hA0; m_state = 0;
      @(negedge clk); rst_n = 1'b1;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule